// File: doc/BRIEF.md
# Column Ones-Count Partial-Product Accumulator

This block sums the partial-product matrix of an n-by-n unsigned multiplication one row per clock. Each accepted row carries one bit for every column of weight 0 to 2n-2. Every column owns a small counter that steps up by one when its bit is set, so the per-cycle loop never carries across columns. Once the final row of a multiplication is in, the column counts are weighted by their column position, compressed by a carry-save chain into a sum row and a carry row, and merged by a carry-propagate adder into the 2n-bit product.

A multiplication starts with a clear, which may arrive together with the first row. The row flagged as last closes the accumulation. One cycle later a single-cycle done pulse marks the product as valid. From then on, further rows are ignored and the product stays fixed until the next clear. The final adder is chosen at elaboration time: either a ripple-carry chain or a parallel-prefix carry-lookahead network.

Top module: `pp_column_accum`

## Requirements
- R1: When a row is accepted, each column counter whose row bit is 1 increases by exactly one on the next clock edge. A row is accepted when `row_valid_i` is high and either `clear_i` is high or no finished result is being held.
- R2: A column counter keeps its value in any cycle where its row bit is 0, `row_valid_i` is low, or a finished result is being held, unless `clear_i` is high.
- R3: Each counter is $clog2(n+1) bits wide. Column c never counts beyond its height, min(c+1, 2n-1-c). With n=8, an all-ones 8x8 matrix gives a product of 0xFE01.
- R4: `product_o` equals the sum over all columns of count(c)*2^c, modulo 2^(2n). This value is formed from exactly two carry-save rows and one carry-propagate addition.
- R5: The ripple-carry build and the carry-lookahead build give the same `product_o` in every cycle for the same inputs.
- R6: `done_o` is high for exactly one cycle, in the cycle after a row flagged by `last_i` is accepted. It is low at all other times.
- R7: After the last row is accepted and until `clear_i`, rows are ignored and `product_o` does not change.
- R8: `clear_i` zeroes every counter and ends the hold. If a row arrives in the same cycle, that row is counted as the first row of the new multiplication. A clear without a row makes `product_o` 0 on the next cycle.
- R9: After reset, all counters are zero, `done_o` is 0 and `product_o` is 0.
- R10: When the n rows of an n-bit multiplication are fed in n consecutive cycles, in any row order, the correct product X*Y is present together with `done_o` in the cycle after the last row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous start of a new multiplication |
| row_valid_i | input | 1 | A partial-product row is present on `row_i` |
| row_i | input | 2*OP_W-1 | One bit per column; bit c has weight 2^c |
| last_i | input | 1 | Marks the row on `row_i` as the final row |
| done_o | output | 1 | One-cycle pulse: product is valid |
| product_o | output | 2*OP_W | Weighted sum of the column counts |

## Verification
The clear that starts one multiplication can coincide with the done pulse of the previous one. In that same cycle, a new first row may also arrive together with the clear. The bench provokes this by feeding two multiplications back to back, with the second one's first row carrying the clear in the cycle right after the first one's last row. A cycle-accurate behavioural model is used to judge the result: the done pulse must still appear, the old counts must not leak into the new sum, and the new first row must be counted. Rows sent during the hold, and gaps inside a multiplication, are compared against the same model on every clock.

// File: rtl/pp_accum_pkg.sv
package pp_accum_pkg;

    typedef enum logic {
        ADD_RIPPLE    = 1'b0,
        ADD_LOOKAHEAD = 1'b1
    } adder_kind_e;

    // Number of partial-product bits that can land in column col
    function automatic int col_height(int col, int n);
        return (col < n) ? col + 1 : 2 * n - 1 - col;
    endfunction

endpackage

// File: rtl/pp_weight_csa.sv
module pp_weight_csa #(
    parameter int NCOL  = 15,
    parameter int CNT_W = 4,
    parameter int PW    = 16
) (
    input  logic [NCOL-1:0][CNT_W-1:0] cnt_i,
    output logic [PW-1:0]              sum_o,
    output logic [PW-1:0]              carry_o
);
    localparam int WIDE_W = PW + CNT_W;

    logic [CNT_W-1:0][WIDE_W-1:0] wide_rows;
    logic [PW-1:0] ps [1:CNT_W-1];
    logic [PW-1:0] pc [1:CNT_W-1];

    // Bit k of counter c has weight 2^(c+k): one row per counter bit
    always_comb begin
        wide_rows = '0;
        for (int k = 0; k < CNT_W; k++) begin
            for (int c = 0; c < NCOL; c++) begin
                wide_rows[k][c+k] = cnt_i[c][k];
            end
        end
    end

    assign ps[1] = wide_rows[0][PW-1:0];
    assign pc[1] = wide_rows[1][PW-1:0];

    // Linear chain of 3:2 compressors down to two rows
    for (genvar k = 2; k < CNT_W; k++) begin : g_csa
        logic [PW-1:0] row_k;
        logic [PW-1:0] maj;
        assign row_k = wide_rows[k][PW-1:0];
        assign maj   = (ps[k-1] & pc[k-1]) | (ps[k-1] & row_k) | (pc[k-1] & row_k);
        assign ps[k] = ps[k-1] ^ pc[k-1] ^ row_k;
        assign pc[k] = {maj[PW-2:0], 1'b0};
    end

    assign sum_o   = ps[CNT_W-1];
    assign carry_o = pc[CNT_W-1];

endmodule

// File: rtl/pp_final_adder.sv
module pp_final_adder
    import pp_accum_pkg::*;
#(
    parameter int          W    = 16,
    parameter adder_kind_e KIND = ADD_LOOKAHEAD
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    localparam int LV = $clog2(W);

    if (KIND == ADD_RIPPLE) begin : g_ripple
        always_comb begin
            logic cy;
            cy = 1'b0;
            for (int i = 0; i < W; i++) begin
                sum_o[i] = a_i[i] ^ b_i[i] ^ cy;
                cy       = (a_i[i] & b_i[i]) | (cy & (a_i[i] ^ b_i[i]));
            end
        end
    end else begin : g_lookahead
        // Parallel-prefix carries: generate when both 1, kill when both 0,
        // propagate when exactly one is 1
        always_comb begin
            logic [W-1:0] gl [0:LV];
            logic [W-1:0] pl [0:LV];
            gl[0] = a_i & b_i;
            pl[0] = a_i ^ b_i;
            for (int l = 0; l < LV; l++) begin
                for (int i = 0; i < W; i++) begin
                    if (i >= (1 << l)) begin
                        gl[l+1][i] = gl[l][i] | (pl[l][i] & gl[l][i-(1<<l)]);
                        pl[l+1][i] = pl[l][i] & pl[l][i-(1<<l)];
                    end else begin
                        gl[l+1][i] = gl[l][i];
                        pl[l+1][i] = 1'b0;
                    end
                end
            end
            sum_o[0] = pl[0][0];
            for (int i = 1; i < W; i++) begin
                sum_o[i] = pl[0][i] ^ gl[LV][i-1];
            end
        end
    end

endmodule

// File: rtl/pp_column_accum.sv
module pp_column_accum
    import pp_accum_pkg::*;
#(
    parameter int          OP_W       = 8,
    parameter adder_kind_e ADDER_KIND = ADD_LOOKAHEAD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                row_valid_i,
    input  logic [2*OP_W-2:0]   row_i,
    input  logic                last_i,
    output logic                done_o,
    output logic [2*OP_W-1:0]   product_o
);
    localparam int NCOL  = 2 * OP_W - 1;
    localparam int PW    = 2 * OP_W;
    localparam int CNT_W = $clog2(OP_W + 1);

    typedef struct packed {
        logic [NCOL-1:0][CNT_W-1:0] cnt;
        logic                       hold;
        logic                       done;
    } state_t;

    state_t st_d, st_q;
    logic   take_row;
    logic [PW-1:0] red_sum, red_carry;

    assign take_row = row_valid_i & (clear_i | ~st_q.hold);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clear_i) begin
            st_d.cnt  = '0;
            st_d.hold = 1'b0;
        end
        if (take_row) begin
            for (int c = 0; c < NCOL; c++) begin
                st_d.cnt[c] = st_d.cnt[c] + CNT_W'(row_i[c]);
            end
            st_d.hold = last_i;
            st_d.done = last_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pp_weight_csa #(.NCOL(NCOL), .CNT_W(CNT_W), .PW(PW)) u_csa (
        .cnt_i   (st_q.cnt),
        .sum_o   (red_sum),
        .carry_o (red_carry)
    );

    pp_final_adder #(.W(PW), .KIND(ADDER_KIND)) u_cpa (
        .a_i   (red_sum),
        .b_i   (red_carry),
        .sum_o (product_o)
    );

    assign done_o = st_q.done;

    function automatic logic [PW-1:0] weigh(input logic [NCOL-1:0][CNT_W-1:0] cv);
        logic [PW-1:0] acc;
        acc = '0;
        for (int c = 0; c < NCOL; c++) acc = acc + (PW'(cv[c]) << c);
        return acc;
    endfunction

    for (genvar c = 0; c < NCOL; c++) begin : g_col_chk
        assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (row_valid_i && !clear_i && !st_q.hold) |=>
            (st_q.cnt[c] == $past(st_q.cnt[c]) + CNT_W'($past(row_i[c]))));
        assert_count_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!clear_i && !(row_valid_i && !st_q.hold && row_i[c])) |=> $stable(st_q.cnt[c]));
        assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.cnt[c] <= CNT_W'(col_height(c, OP_W)));
    end

    assert_two_rows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        product_o == weigh(st_q.cnt));
    assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid_i && last_i && (clear_i || !st_q.hold)) |=> done_o);
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !(clear_i && row_valid_i && last_i)) |=> !done_o);
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hold && !clear_i) |=> $stable(product_o));
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !row_valid_i) |=> (product_o == '0 && !done_o));

endmodule

// File: tb/pp_column_accum_bench.sv
module pp_column_accum_bench;
    import pp_accum_pkg::*;

    localparam int N    = 8;
    localparam int NCOL = 2 * N - 1;
    localparam int PW   = 2 * N;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clear_i = 1'b0;
    logic            row_valid_i = 1'b0;
    logic [NCOL-1:0] row_i = '0;
    logic            last_i = 1'b0;
    logic            done_la, done_rc;
    logic [PW-1:0]   prod_la, prod_rc;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int ref_cnt [NCOL];
    bit ref_hold = 1'b0;
    bit ref_done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pp_column_accum #(.OP_W(N), .ADDER_KIND(ADD_LOOKAHEAD)) u_pp_column_accum (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .row_valid_i(row_valid_i),
        .row_i(row_i), .last_i(last_i), .done_o(done_la), .product_o(prod_la));

    pp_column_accum #(.OP_W(N), .ADDER_KIND(ADD_RIPPLE)) u_pp_column_accum_rc (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .row_valid_i(row_valid_i),
        .row_i(row_i), .last_i(last_i), .done_o(done_rc), .product_o(prod_rc));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [PW-1:0] ref_product();
        longint s = 0;
        for (int c = 0; c < NCOL; c++) s += longint'(ref_cnt[c]) << c;
        return PW'(s);
    endfunction

    // Behavioural reference, updated at each edge from the inputs in force
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (ref_cnt[c]) ref_cnt[c] = 0;
            ref_hold = 0;
            ref_done = 0;
        end else begin
            ref_done = 0;
            if (clear_i) begin
                foreach (ref_cnt[c]) ref_cnt[c] = 0;
                ref_hold = 0;
            end
            if (row_valid_i && (clear_i || !ref_hold)) begin
                foreach (ref_cnt[c]) ref_cnt[c] += int'(row_i[c]);
                ref_hold = last_i;
                ref_done = last_i;
            end
        end
    end

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check(prod_la == ref_product(), "R1 R2 R4 count sum", prod_la, ref_product());
            check(done_la == ref_done, "R6 done pulse", done_la, ref_done);
            check(prod_rc == prod_la, "R5 ripple vs lookahead", prod_rc, prod_la);
            check(done_rc == done_la, "R5 done match", done_rc, done_la);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic drive(input bit v, input logic [NCOL-1:0] r, input bit l, input bit c);
        @(negedge clk);
        row_valid_i = v;
        row_i       = r;
        last_i      = l;
        clear_i     = c;
    endtask

    task automatic run_mult(input logic [N-1:0] x, input logic [N-1:0] y,
                            input bit rev, input bit gap, input bit start_clear);
        for (int k = 0; k < N; k++) begin
            int r;
            logic [NCOL-1:0] row;
            r   = rev ? N - 1 - k : k;
            row = y[r] ? (NCOL'(x) << r) : '0;
            drive(1'b1, row, k == N - 1, start_clear && k == 0);
            if (gap && k == 2) drive(1'b0, '1, 1'b0, 1'b0);
        end
        drive(1'b0, '0, 1'b0, 1'b0);
        check(done_la == 1'b1, "R10 R6 done after last row", done_la, 1);
        check(prod_la == PW'(x * y), "R10 R4 product", prod_la, PW'(x * y));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(prod_la == '0, "R9 reset product", prod_la, 0);
        check(done_la == 1'b0, "R9 reset done", done_la, 0);
        rst_n = 1'b1;
        drive(1'b0, '0, 1'b0, 1'b1);
        run_mult(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0);
        // R7: rows during hold are ignored
        for (int i = 0; i < 3; i++) drive(1'b1, '1, i == 2, 1'b0);
        drive(1'b0, '0, 1'b0, 1'b0);
        check(prod_la == PW'(16'hA5 * 16'h3C), "R7 held product", prod_la, 16'hA5 * 16'h3C);
        check(done_la == 1'b0, "R7 no done in hold", done_la, 0);
        // R8: bare clear
        drive(1'b0, '0, 1'b0, 1'b1);
        drive(1'b0, '0, 1'b0, 1'b0);
        check(prod_la == '0, "R8 clear zeroes", prod_la, 0);
        // R3: full column heights
        run_mult(8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1);
        check(prod_la == 16'hFE01, "R3 full matrix", prod_la, 16'hFE01);
        // Reversed row order, then gap inside (R2), back-to-back with clear (R8)
        run_mult(8'h81, 8'hC3, 1'b1, 1'b0, 1'b1);
        run_mult(8'h7E, 8'h99, 1'b0, 1'b1, 1'b1);
        for (int k = 0; k < N; k++) begin
            logic [NCOL-1:0] row;
            row = ((8'h5A >> k) & 1) != 0 ? (NCOL'(8'hE7) << k) : '0;
            drive(1'b1, row, k == N - 1, k == 0);
        end
        for (int k = 0; k < N; k++) begin
            logic [NCOL-1:0] row;
            row = ((8'h13 >> k) & 1) != 0 ? (NCOL'(8'h2F) << k) : '0;
            drive(1'b1, row, k == N - 1, k == 0);
            if (k == 0) check(done_la == 1'b1, "R8 clear with row meets done", done_la, 1);
        end
        drive(1'b0, '0, 1'b0, 1'b0);
        check(prod_la == PW'(16'h2F * 16'h13), "R8 back-to-back product", prod_la, 16'h2F * 16'h13);
        run_mult(8'h00, 8'hFF, 1'b0, 1'b0, 1'b1);
        run_mult(8'h01, 8'h01, 1'b1, 1'b0, 1'b1);
        repeat (2) drive(1'b0, '0, 1'b0, 1'b0);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule